// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block carries a valid bit, a program counter and an exception cause beside every instruction in a five-stage pipeline (fetch, decode, execute, memory, writeback). Each stage has one detector input that flags a fault in the instruction currently in that stage. A flag is not acted on where it is raised. It is encoded as a cause and moves down the pipeline with its instruction.

The only place an exception is resolved is the end of the memory stage. When a flagged, valid instruction is there, the block takes the exception in that cycle. It asserts the redirect with the fixed vector address, and at the closing edge it latches the instruction's PC and cause. It also clears the valid bit of every younger instruction and of the fetch slot. A faulting instruction never gets memory-write permission and never enters writeback, so architectural state stops just before it. An external interrupt enters at fetch as a no-op that already carries a fault. This puts it in program order with everything else.

The surrounding core uses `mem_wr_en_o` to gate data-memory writes and `wb_valid_o` to gate register-file writes. It uses `take_o` with `redirect_pc_o` to load the program counter.

Top module: `exc_precise_tracker`

## Requirements
- R1: While reset is asserted, and after it is released until the first exception, `take_o`, `mem_wr_en_o` and `wb_valid_o` are 0, and `epc_o` and `cause_o` are 0.
- R2: A slot enters the pipeline when `fetch_valid_i` or `irq_i` is high. The slot's cause is 5 (interrupt) if `irq_i` is high. Otherwise it is 1 (instruction address fault) if `fetch_fault_i` is high, and 0 (none) if neither is high. The slot carries `fetch_pc_i` as its PC.
- R3: `dec_fault_i` attaches cause 2 (illegal opcode) to the instruction in decode. `exe_fault_i` attaches cause 3 (overflow) to the instruction in execute. `mem_fault_i` attaches cause 4 (data address fault) to the instruction in memory. Each of these inputs has no effect when its stage holds no valid instruction.
- R4: An instruction that already carries a cause keeps it. A later stage's fault input does not overwrite it.
- R5: `take_o` is high in exactly the cycle when a valid instruction with a nonzero cause is in the memory stage. In that same cycle, `redirect_pc_o` equals the parameter `VECTOR`. In all other cycles, `redirect_pc_o` is 0.
- R6: At the edge that ends a take cycle, `epc_o` becomes the PC of the instruction in the memory stage and `cause_o` becomes its cause. Both hold their values until the next take.
- R7: On a take, the instructions in decode, execute and memory and the slot at fetch are all invalidated. None of them later produces `mem_wr_en_o`, `wb_valid_o` or `take_o`.
- R8: `mem_wr_en_o` is high only for a valid, unflagged instruction in the memory stage. `wb_valid_o` rises one cycle later for that instruction, with `wb_pc_o` equal to its PC. A flagged instruction never reaches writeback.
- R9: Exceptions are taken in program order. An older instruction's fault found in memory is taken before a younger instruction's fault found earlier at fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | An instruction is fetched this cycle |
| fetch_pc_i | input | PC_W | PC of the fetch slot |
| fetch_fault_i | input | 1 | Fetch address fault for this slot |
| irq_i | input | 1 | Insert an external interrupt as a faulting no-op |
| dec_fault_i | input | 1 | Illegal opcode in decode |
| exe_fault_i | input | 1 | Overflow in execute |
| mem_fault_i | input | 1 | Data address fault or memory error in memory stage |
| take_o | output | 1 | Exception taken this cycle |
| redirect_pc_o | output | PC_W | Vector address while `take_o` is high, else 0 |
| mem_wr_en_o | output | 1 | Memory-stage instruction may write memory |
| wb_valid_o | output | 1 | Writeback instruction may write registers |
| wb_pc_o | output | PC_W | PC of the writeback instruction |
| epc_o | output | PC_W | Saved PC of the last taken exception |
| cause_o | output | 3 | Cause of the last taken exception |

## Verification
The vector table runs a continuous instruction stream. In it, one instruction gets a decode flag and then an execute flag, a memory flag lands on a squashed slot, a fetch bubble passes through, and a second exception follows. This separates the cause being kept from the cause being overwritten, and squashed slots from live ones in both the write enables and the saved PC. Directed sequences then check three cases one at a time: an interrupt alone, a fetch fault followed by younger instructions, and an older memory fault racing a younger fetch fault. These cases separate the correct cause codes and vector redirect from simple first-detected ordering.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_IADDR = 3'd1,
    C_ILLOP = 3'd2,
    C_OVF   = 3'd3,
    C_DADDR = 3'd4,
    C_IRQ   = 3'd5
  } cause_e;

  // Earliest-detected cause wins.
  function automatic cause_e merge_cause(cause_e prior, logic flag, cause_e code);
    if (prior != C_NONE) return prior;
    if (flag)            return code;
    return C_NONE;
  endfunction

  // Cause injected while an instruction sits in stage k (0 fetch, 1 decode, 2 execute).
  function automatic cause_e stage_code(int k);
    case (k)
      1:       return C_ILLOP;
      2:       return C_OVF;
      default: return C_NONE;
    endcase
  endfunction
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int     PC_W = 32,
  parameter cause_e CODE = C_NONE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            in_valid_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  cause_e          in_cause_i,
  input  logic            fault_i,
  output logic            out_valid_o,
  output logic [PC_W-1:0] out_pc_o,
  output cause_e          out_cause_o
);
  cause_e nxt_cause;
  assign nxt_cause = merge_cause(in_cause_i, fault_i & in_valid_i, CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pc_o    <= '0;
      out_cause_o <= C_NONE;
    end else begin
      out_valid_o <= in_valid_i & ~flush_i;
      out_pc_o    <= in_pc_i;
      out_cause_o <= in_valid_i ? nxt_cause : C_NONE;
    end
  end

  p_cause_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_cause_i != C_NONE) |=> (out_cause_o == $past(in_cause_i)));

  p_flush_kills_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
#(
  parameter int              PC_W   = 32,
  parameter logic [PC_W-1:0] VECTOR = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mem_valid_i,
  input  logic [PC_W-1:0] mem_pc_i,
  input  cause_e          mem_cause_i,
  input  logic            mem_fault_i,
  output logic            take_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            mem_wr_en_o,
  output logic            wb_valid_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic [PC_W-1:0] epc_o,
  output cause_e          cause_o
);
  cause_e fin_cause;
  assign fin_cause     = merge_cause(mem_cause_i, mem_fault_i, C_DADDR);
  assign take_o        = mem_valid_i && (fin_cause != C_NONE);
  assign mem_wr_en_o   = mem_valid_i && (fin_cause == C_NONE);
  assign redirect_pc_o = take_o ? VECTOR : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o      <= '0;
      cause_o    <= C_NONE;
      wb_valid_o <= 1'b0;
      wb_pc_o    <= '0;
    end else begin
      wb_valid_o <= mem_wr_en_o;
      wb_pc_o    <= mem_pc_i;
      if (take_o) begin
        epc_o   <= mem_pc_i;
        cause_o <= fin_cause;
      end
    end
  end

  p_epc_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (epc_o == $past(mem_pc_i)));

  p_epc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> ($stable(epc_o) && $stable(cause_o)));

  p_no_write_on_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !mem_wr_en_o);

  p_fault_never_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !wb_valid_o);
endmodule

// File: rtl/exc_precise_tracker.sv
module exc_precise_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W   = 32,
  parameter logic [PC_W-1:0] VECTOR = 32'h0000_0080
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_fault_i,
  input  logic            irq_i,
  input  logic            dec_fault_i,
  input  logic            exe_fault_i,
  input  logic            mem_fault_i,
  output logic            take_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            mem_wr_en_o,
  output logic            wb_valid_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [2:0]      cause_o
);
  localparam int NSTG = 3;  // registers holding decode, execute, memory

  // Index 0 is the fetch slot; index k+1 is the register after stage k.
  logic            s_valid [NSTG+1];
  logic [PC_W-1:0] s_pc    [NSTG+1];
  cause_e          s_cause [NSTG+1];
  logic [NSTG-1:0] s_fault;
  logic            take;
  cause_e          cause_q;

  assign s_valid[0] = fetch_valid_i | irq_i;
  assign s_pc[0]    = fetch_pc_i;
  assign s_cause[0] = irq_i ? C_IRQ : (fetch_fault_i ? C_IADDR : C_NONE);
  assign s_fault    = {exe_fault_i, dec_fault_i, 1'b0};

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    exc_stage_reg #(.PC_W(PC_W), .CODE(stage_code(k))) u_reg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (take),
      .in_valid_i  (s_valid[k]),
      .in_pc_i     (s_pc[k]),
      .in_cause_i  (s_cause[k]),
      .fault_i     (s_fault[k]),
      .out_valid_o (s_valid[k+1]),
      .out_pc_o    (s_pc[k+1]),
      .out_cause_o (s_cause[k+1])
    );
  end

  exc_commit #(.PC_W(PC_W), .VECTOR(VECTOR)) u_commit (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mem_valid_i   (s_valid[NSTG]),
    .mem_pc_i      (s_pc[NSTG]),
    .mem_cause_i   (s_cause[NSTG]),
    .mem_fault_i   (mem_fault_i),
    .take_o        (take),
    .redirect_pc_o (redirect_pc_o),
    .mem_wr_en_o   (mem_wr_en_o),
    .wb_valid_o    (wb_valid_o),
    .wb_pc_o       (wb_pc_o),
    .epc_o         (epc_o),
    .cause_o       (cause_q)
  );

  assign take_o  = take;
  assign cause_o = cause_q;

  p_take_only_flagged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> s_valid[NSTG]);

  p_no_take_after_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
endmodule

// File: tb/tb_exc_precise_tracker.sv
module tb_exc_precise_tracker;
  localparam int          PC_W = 32;
  localparam logic [31:0] VEC  = 32'h0000_0080;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fv = 0, ff = 0, irq = 0, idf = 0, exf = 0, mf = 0;
  logic [PC_W-1:0] fpc = '0;
  logic take, mwr, wbv;
  logic [PC_W-1:0] rpc, wpc, epc;
  logic [2:0] cause;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  exc_precise_tracker #(.PC_W(PC_W), .VECTOR(VEC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_valid_i(fv), .fetch_pc_i(fpc),
    .fetch_fault_i(ff), .irq_i(irq), .dec_fault_i(idf), .exe_fault_i(exf),
    .mem_fault_i(mf), .take_o(take), .redirect_pc_o(rpc), .mem_wr_en_o(mwr),
    .wb_valid_o(wbv), .wb_pc_o(wpc), .epc_o(epc), .cause_o(cause));

  typedef struct packed {
    logic [5:0]  in;    // fv ff irq idf exf mf
    logic [2:0]  exp;   // take mwr wbv
    logic [2:0]  cause;
    logic [15:0] epc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{6'b100000, 3'b000, 3'd0, 16'h0000},  // 0 fetch A
    '{6'b100000, 3'b000, 3'd0, 16'h0000},  // 1 fetch B
    '{6'b100100, 3'b000, 3'd0, 16'h0000},  // 2 B illegal in decode
    '{6'b100010, 3'b010, 3'd0, 16'h0000},  // 3 B overflow too; A writes mem
    '{6'b100000, 3'b101, 3'd0, 16'h0000},  // 4 B taken, A in wb
    '{6'b100000, 3'b000, 3'd2, 16'h0104},  // 5 cause 2 kept
    '{6'b100000, 3'b000, 3'd2, 16'h0104},  // 6 squashed
    '{6'b100001, 3'b000, 3'd2, 16'h0104},  // 7 mem fault on squashed slot
    '{6'b000000, 3'b010, 3'd2, 16'h0104},  // 8 F writes mem
    '{6'b101010, 3'b011, 3'd2, 16'h0104},  // 9 irq slot; H overflow
    '{6'b100000, 3'b101, 3'd2, 16'h0104},  // 10 H taken
    '{6'b000000, 3'b000, 3'd3, 16'h011C},  // 11
    '{6'b000000, 3'b000, 3'd3, 16'h011C},  // 12 irq slot squashed
    '{6'b000000, 3'b000, 3'd3, 16'h011C}   // 13
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v, input logic [31:0] pc);
    @(negedge clk);
    {fv, ff, irq, idf, exf, mf} = v;
    fpc = pc;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    {fv, ff, irq, idf, exf, mf} = '0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #80000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1 take", {31'd0, take}, 0);
    chk("R1 wr/wb", {30'd0, mwr, wbv}, 0);
    chk("R1 epc", epc, 0);
    chk("R1 cause", {29'd0, cause}, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].in, 32'h100 + 32'(4 * i));
      chk($sformatf("R5/R7/R8 row%0d take,mwr,wbv", i), {29'd0, take, mwr, wbv}, {29'd0, TBL[i].exp});
      chk($sformatf("R4/R6 row%0d cause", i), {29'd0, cause}, {29'd0, TBL[i].cause});
      chk($sformatf("R6 row%0d epc", i), epc, {16'd0, TBL[i].epc});
      if (TBL[i].exp[0] && i == 4) chk("R8 wb pc", wpc, 32'h100);
    end

    // R2: interrupt as faulting no-op, wins over fetch fault
    do_reset();
    drive(6'b111000, 32'h200);
    drive(6'b000000, 0);
    drive(6'b000000, 0);
    drive(6'b000000, 0);
    chk("R2/R5 irq take", {31'd0, take}, 1);
    chk("R5 redirect", rpc, VEC);
    drive(6'b000000, 0);
    chk("R2 irq cause", {29'd0, cause}, 5);
    chk("R2 irq epc", epc, 32'h200);
    chk("R5 redirect idle", rpc, 0);

    // R2: fetch fault, younger instructions squashed (R7)
    do_reset();
    drive(6'b110000, 32'h300);
    drive(6'b100000, 32'h304);
    drive(6'b100000, 32'h308);
    drive(6'b100000, 32'h30C);
    chk("R2 fetch fault take", {31'd0, take}, 1);
    drive(6'b000000, 0);
    chk("R2 fetch cause", {29'd0, cause}, 1);
    chk("R7 younger no write", {30'd0, take, mwr}, 0);
    drive(6'b000000, 0);
    chk("R7 younger no wb", {30'd0, mwr, wbv}, 0);

    // R9: older data fault beats younger earlier fetch fault
    do_reset();
    drive(6'b100000, 32'h400);
    drive(6'b110000, 32'h404);
    drive(6'b000000, 0);
    drive(6'b000001, 0);
    chk("R9/R3 older mem fault take", {31'd0, take}, 1);
    drive(6'b000000, 0);
    chk("R9 cause", {29'd0, cause}, 4);
    chk("R9 epc", epc, 32'h400);
    chk("R9 younger squashed", {31'd0, take}, 0);
    drive(6'b000000, 0);
    chk("R9 state held", {29'd0, cause}, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule